// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block collects up to 32 interrupt inputs and routes each one to any set of up to 32 hardware threads. Software programs two words per input. The first word is a thread mask. The second word holds an enable bit, a trigger selection bit, a mode bit and a 6-bit CPU vector. The controller holds a pending bit for each input. For every thread it shows a request line, together with the vector of the highest-priority pending input that is enabled and routed to that thread.

Software clears pending bits by writing ones to an acknowledge word. A separate doorbell word sends an inter-processor interrupt. It carries a vector to one thread, and that thread is addressed by a core number and a thread-within-core number. The doorbell stays raised until the target thread pulses its own acknowledge strobe. A plain 32-bit control word is also provided. Software reads it and writes it back whole.

All registers sit on a simple word-addressed port. Writes take effect on the next clock edge. Reads are combinational from the current state.

Top module: `irq_route_ctrl`

## Requirements
- R1: After synchronous reset, every routing word, every pending bit, the control word and every doorbell read as 0, and all `irq_req` lines are low.
- R2: The mask word of input n is at word address 0x40+n. It reads back exactly the 32-bit value last written, and bit t routes the input to thread t.
- R3: The control word of input n is at word address 0x80+n. Bit 31 is enable, bit 30 is trigger select, bit 6 is mode, and bits 5:0 are the vector. All other bits read 0.
- R4: Inputs 1 to 8 are always edge-triggered. Any other input is edge-triggered when its bit 30 is 1. An edge input becomes pending only on a 0-to-1 change, so an input held high does not pend again after an acknowledge.
- R5: An input whose bit 30 is 0, other than inputs 1 to 8, is level-triggered. It becomes pending in any cycle in which it is high, and it stays pending after it falls until it is acknowledged.
- R6: Writing word address 0x06 clears the pending bit of every input whose data bit is 1, and leaves the other inputs unchanged. The clear takes priority over a set in the same cycle, so a level input that is still high pends again one cycle later. Reading 0x06 returns the pending bits, with bit n belonging to input n.
- R7: Thread t requests when some pending input has enable 1 and mask bit t set. Its vector, `irq_vec[6t+5:6t]`, is that of the lowest-numbered such input.
- R8: A pending input whose enable bit is 0 raises no request. Setting the enable bit later delivers it.
- R9: Writing word address 0x04 raises a doorbell for thread 4*core+thread. The core number is in bits 22:20, the thread-within-core number is in bits 17:16, and the vector is in bits 5:0. A raised doorbell drives that thread's request, and its vector outranks any input vector.
- R10: A doorbell stays raised until `ipi_ack[t]` is high at a clock edge. A doorbell write to the same thread in that same cycle wins over the acknowledge.
- R11: The control word at address 0x00 reads back all 32 bits last written.
- R12: Writes to addresses outside the map are ignored. Reads of such addresses, and of the doorbell address, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_in | input | NUM_SRC (32) | Interrupt inputs |
| ipi_ack | input | NUM_THR (32) | Per-thread doorbell acknowledge strobe |
| irq_req | output | NUM_THR (32) | Per-thread request |
| irq_vec | output | NUM_THR*6 (192) | Per-thread vector, 6 bits per thread |

## Verification
The bench builds the block with its defaults: 32 inputs, 32 threads, and edge-only inputs 1 to 8. With 32 threads, the last core/thread code (core 7, thread 3 → thread 31) is reachable, as are both ends of the fixed edge range. Input 30 is used to show that an input outside that range can be made edge-triggered through its control word. The cases covered are: acknowledge racing a level set, a doorbell write racing its acknowledge, and doorbell priority over an input already being delivered.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int VEC_W  = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IPI  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h06;
    localparam logic [1:0]        BANK_MASK = 2'b01;
    localparam logic [1:0]        BANK_CTL  = 2'b10;

    localparam int CTL_EN_BIT   = 31;
    localparam int CTL_EDGE_BIT = 30;
    localparam int CTL_MODE_BIT = 6;

    localparam int IPI_CORE_LSB = 20;
    localparam int IPI_CORE_W   = 3;
    localparam int IPI_THR_LSB  = 16;
    localparam int IPI_THR_W    = 2;
    localparam int IPI_TGT_W    = IPI_CORE_W + IPI_THR_W;

    typedef struct packed {
        logic             en;
        logic             edge_sel;
        logic             mode;
        logic [VEC_W-1:0] vec;
    } route_ctl_t;
endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_THR = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_SRC-1:0][NUM_THR-1:0]  mask_q,
    output route_ctl_t [NUM_SRC-1:0]         ctl_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0][NUM_THR-1:0] mask;
        route_ctl_t [NUM_SRC-1:0]        ctl;
    } table_t;

    table_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (we && addr[5:0] == 6'(n)) begin
                if (addr[7:6] == BANK_MASK) begin
                    s_d.mask[n] = wdata[NUM_THR-1:0];
                end
                if (addr[7:6] == BANK_CTL) begin
                    s_d.ctl[n].en       = wdata[CTL_EN_BIT];
                    s_d.ctl[n].edge_sel = wdata[CTL_EDGE_BIT];
                    s_d.ctl[n].mode     = wdata[CTL_MODE_BIT];
                    s_d.ctl[n].vec      = wdata[VEC_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign mask_q = s_q.mask;
    assign ctl_q  = s_q.ctl;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int NUM_SRC = 32,
    parameter int EDGE_LO = 1,
    parameter int EDGE_HI = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] edge_cfg,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] ack_bits,
    output logic [NUM_SRC-1:0] pend_q
);
    function automatic logic [NUM_SRC-1:0] fixed_edges();
        logic [NUM_SRC-1:0] r;
        for (int n = 0; n < NUM_SRC; n++) r[n] = (n >= EDGE_LO) && (n <= EDGE_HI);
        return r;
    endfunction

    localparam logic [NUM_SRC-1:0] FIXED_EDGE = fixed_edges();

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] prev;
    } pend_t;

    pend_t              s_d, s_q;
    logic [NUM_SRC-1:0] is_edge;
    logic [NUM_SRC-1:0] set_now;

    always_comb begin
        is_edge   = FIXED_EDGE | edge_cfg;
        set_now   = (is_edge & src_in & ~s_q.prev) | (~is_edge & src_in);
        s_d.prev  = src_in;
        s_d.pend  = (s_q.pend | set_now) & ~(ack_we ? ack_bits : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pend_q = s_q.pend;
endmodule

// File: rtl/irq_thread_pick.sv
module irq_thread_pick
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_THR = 32
) (
    input  logic [NUM_SRC-1:0]              pend,
    input  logic [NUM_SRC-1:0]              src_en,
    input  logic [NUM_SRC-1:0][VEC_W-1:0]   src_vec,
    input  logic [NUM_SRC-1:0][NUM_THR-1:0] mask,
    input  logic [NUM_THR-1:0]              ipi_pend,
    input  logic [NUM_THR-1:0][VEC_W-1:0]   ipi_vec,
    output logic [NUM_THR-1:0]              req,
    output logic [NUM_THR*VEC_W-1:0]        vec
);
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic             hit;
        logic [VEC_W-1:0] pick;

        always_comb begin
            hit  = 1'b0;
            pick = '0;
            for (int n = NUM_SRC - 1; n >= 0; n--) begin
                if (pend[n] && src_en[n] && mask[n][t]) begin
                    hit  = 1'b1;
                    pick = src_vec[n];
                end
            end
        end

        assign req[t]                 = ipi_pend[t] | hit;
        assign vec[t*VEC_W +: VEC_W]  = ipi_pend[t] ? ipi_vec[t] : pick;
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_THR = 32,
    parameter int EDGE_LO = 1,
    parameter int EDGE_HI = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_SRC-1:0]       src_in,
    input  logic [NUM_THR-1:0]       ipi_ack,
    output logic [NUM_THR-1:0]       irq_req,
    output logic [NUM_THR*VEC_W-1:0] irq_vec
);
    typedef struct packed {
        logic [DATA_W-1:0]             ctrl;
        logic [NUM_THR-1:0]            ipi_pend;
        logic [NUM_THR-1:0][VEC_W-1:0] ipi_vec;
    } top_t;

    top_t                            s_d, s_q;
    logic [NUM_SRC-1:0][NUM_THR-1:0] mask_q;
    route_ctl_t [NUM_SRC-1:0]        ctl_q;
    logic [NUM_SRC-1:0]              pend_q;
    logic [NUM_SRC-1:0]              edge_cfg;
    logic [NUM_SRC-1:0]              src_en;
    logic [NUM_SRC-1:0][VEC_W-1:0]   src_vec;
    logic [NUM_THR-1:0]              ipi_pend_q;
    logic [IPI_TGT_W-1:0]            ipi_tgt;
    logic                            ipi_wr;
    logic                            ack_we;

    assign ipi_tgt    = {reg_wdata[IPI_CORE_LSB +: IPI_CORE_W], reg_wdata[IPI_THR_LSB +: IPI_THR_W]};
    assign ipi_wr     = reg_we && (reg_addr == OFS_IPI);
    assign ack_we     = reg_we && (reg_addr == OFS_ACK);
    assign ipi_pend_q = s_q.ipi_pend;

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++) begin
            edge_cfg[n] = ctl_q[n].edge_sel;
            src_en[n]   = ctl_q[n].en;
            src_vec[n]  = ctl_q[n].vec;
        end
    end

    irq_route_table #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_table (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .mask_q(mask_q), .ctl_q(ctl_q)
    );

    irq_pend_latch #(.NUM_SRC(NUM_SRC), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_pend (
        .clk(clk), .rst(rst), .src_in(src_in), .edge_cfg(edge_cfg),
        .ack_we(ack_we), .ack_bits(reg_wdata[NUM_SRC-1:0]), .pend_q(pend_q)
    );

    irq_thread_pick #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_pick (
        .pend(pend_q), .src_en(src_en), .src_vec(src_vec), .mask(mask_q),
        .ipi_pend(s_q.ipi_pend), .ipi_vec(s_q.ipi_vec),
        .req(irq_req), .vec(irq_vec)
    );

    always_comb begin
        s_d = s_q;
        if (reg_we && reg_addr == OFS_CTRL) s_d.ctrl = reg_wdata;
        for (int t = 0; t < NUM_THR; t++) begin
            s_d.ipi_pend[t] = s_q.ipi_pend[t] & ~ipi_ack[t];
            if (ipi_wr && ipi_tgt == IPI_TGT_W'(t)) begin
                s_d.ipi_pend[t] = 1'b1;
                s_d.ipi_vec[t]  = reg_wdata[VEC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) begin
            reg_rdata = s_q.ctrl;
        end else if (reg_addr == OFS_ACK) begin
            reg_rdata[NUM_SRC-1:0] = pend_q;
        end else begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (reg_addr[5:0] == 6'(n)) begin
                    if (reg_addr[7:6] == BANK_MASK) reg_rdata[NUM_THR-1:0] = mask_q[n];
                    if (reg_addr[7:6] == BANK_CTL) begin
                        reg_rdata[CTL_EN_BIT]   = ctl_q[n].en;
                        reg_rdata[CTL_EDGE_BIT] = ctl_q[n].edge_sel;
                        reg_rdata[CTL_MODE_BIT] = ctl_q[n].mode;
                        reg_rdata[VEC_W-1:0]    = ctl_q[n].vec;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_THR = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_SRC-1:0] src_in,
    input logic [NUM_THR-1:0] ipi_ack,
    input logic [NUM_THR-1:0] irq_req,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_THR-1:0] ipi_pend_q
);
    logic                 ack_wr;
    logic                 bell_wr;
    logic [IPI_TGT_W-1:0] tgt;

    assign ack_wr  = reg_we && (reg_addr == OFS_ACK);
    assign bell_wr = reg_we && (reg_addr == OFS_IPI);
    assign tgt     = {reg_wdata[IPI_CORE_LSB +: IPI_CORE_W], reg_wdata[IPI_THR_LSB +: IPI_THR_W]};

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> ((pend_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_wr |=> (($past(pend_q) & ~pend_q) == '0));

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        // R4
        pend_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_q[n]) |-> $past(src_in[n]));
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        // R9
        bell_set_chk: assert property (@(posedge clk) disable iff (rst)
            (bell_wr && tgt == IPI_TGT_W'(t)) |=> ipi_pend_q[t]);
        // R10
        bell_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (ipi_pend_q[t] && !ipi_ack[t]) |=> ipi_pend_q[t]);
        // R9
        bell_req_chk: assert property (@(posedge clk) disable iff (rst)
            ipi_pend_q[t] |-> irq_req[t]);
    end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .src_in(src_in), .ipi_ack(ipi_ack), .irq_req(irq_req),
    .pend_q(pend_q), .ipi_pend_q(ipi_pend_q)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;
    localparam int NS = 32;
    localparam int NT = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] src_in = '0;
    logic [NT-1:0] ipi_ack = '0;
    logic [NT-1:0] irq_req;
    logic [NT*6-1:0] irq_vec;

    irq_route_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .ipi_ack(ipi_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    initial begin
        forever begin
            @(chk_ev);
            #0.2;
            while (sb.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = 32'(irq_req[it.idx]);
                    2:       act = 32'(irq_vec[it.idx*6 +: 6]);
                    default: act = irq_req;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input int idx, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        -> chk_ev;
        #0.5;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        push(0, 0, exp, tag);
    endtask

    task automatic req(input int t, input logic e, input string tag);
        push(1, t, 32'(e), tag);
    endtask

    task automatic vec(input int t, input logic [5:0] e, input string tag);
        push(2, t, 32'(e), tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        tick();
        rd(8'h00, 32'h0, "R1 control");
        rd(8'h46, 32'h0, "R1 mask word");
        rd(8'h86, 32'h0, "R1 ctl word");
        rd(8'h06, 32'h0, "R1 pending");
        push(3, 0, 32'h0, "R1 requests");
        tick();

        wr(8'h00, 32'hDEAD_BEEF);
        rd(8'h00, 32'hDEAD_BEEF, "R11 control readback");
        wr(8'h20, 32'h5);
        wr(8'hA5, 32'hFFFF);
        rd(8'h20, 32'h0, "R12 unmapped low");
        rd(8'hA5, 32'h0, "R12 unmapped high");
        rd(8'h00, 32'hDEAD_BEEF, "R12 control untouched");
        rd(8'h85, 32'h0, "R12 table untouched");
        tick();
        rd(8'h04, 32'h0, "R12 doorbell reads zero");

        wr(8'h54, 32'h0000_0005);
        rd(8'h54, 32'h0000_0005, "R2 mask readback");
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, 32'hC000_007F, "R3 field mask");
        wr(8'h94, 32'h8000_002A);
        rd(8'h94, 32'h8000_002A, "R3 fields");

        src_in[20] = 1'b1; tick();
        src_in[20] = 1'b0; tick(); tick();
        rd(8'h06, 32'h0010_0000, "R5 level held pending");
        req(0, 1'b1, "R7 thread0 req");
        vec(0, 6'd42, "R7 thread0 vec");
        req(2, 1'b1, "R7 thread2 req");
        vec(2, 6'd42, "R7 thread2 vec");
        req(1, 1'b0, "R7 thread1 unrouted");
        tick();

        wr(8'h4C, 32'h1);
        wr(8'h8C, 32'h8000_0007);
        src_in[12] = 1'b1; tick();
        src_in[12] = 1'b0; tick();
        rd(8'h06, 32'h0010_1000, "R5 two pending");
        vec(0, 6'd7, "R7 lowest index wins");
        vec(2, 6'd42, "R7 other thread");
        wr(8'h06, 32'h0000_1000);
        rd(8'h06, 32'h0010_0000, "R6 only one bits clear");
        vec(0, 6'd42, "R6 next source delivered");

        src_in[12] = 1'b1; tick();
        rd(8'h06, 32'h0010_1000, "R6 level set");
        wr(8'h06, 32'h0000_1000);
        rd(8'h06, 32'h0010_0000, "R6 ack wins over set");
        tick();
        rd(8'h06, 32'h0010_1000, "R6 level re-pends");
        src_in[12] = 1'b0;
        wr(8'h06, 32'h0010_1000);
        rd(8'h06, 32'h0, "R6 all cleared");
        push(3, 0, 32'h0, "R6 no requests");
        tick();

        wr(8'h59, 32'h2);
        wr(8'h99, 32'h0000_0009);
        src_in[25] = 1'b1; tick();
        rd(8'h06, 32'h0200_0000, "R8 pending while disabled");
        req(1, 1'b0, "R8 disabled no req");
        wr(8'h99, 32'h8000_0009);
        req(1, 1'b1, "R8 enabled req");
        vec(1, 6'd9, "R8 enabled vec");
        src_in[25] = 1'b0;
        wr(8'h06, 32'h0200_0000);
        req(1, 1'b0, "R8 cleared");

        wr(8'h43, 32'h8);
        wr(8'h83, 32'h8000_000D);
        src_in[3] = 1'b1; tick();
        rd(8'h06, 32'h8, "R4 timer edge pends");
        req(3, 1'b1, "R4 timer req");
        vec(3, 6'd13, "R4 timer vec");
        wr(8'h06, 32'h8);
        tick(); tick();
        rd(8'h06, 32'h0, "R4 held high no re-pend");
        req(3, 1'b0, "R4 held high no req");
        src_in[3] = 1'b0; tick();
        src_in[3] = 1'b1; tick();
        rd(8'h06, 32'h8, "R4 new edge pends");
        src_in[3] = 1'b0;
        wr(8'h06, 32'h8);
        rd(8'h06, 32'h0, "R4 cleared");

        wr(8'h9E, 32'hC000_0001);
        src_in[30] = 1'b1; tick();
        rd(8'h06, 32'h4000_0000, "R4 configured edge pends");
        wr(8'h06, 32'h4000_0000);
        tick();
        rd(8'h06, 32'h0, "R4 configured edge held");
        src_in[30] = 1'b0; tick();

        wr(8'h45, 32'h1);
        wr(8'h85, 32'h8000_0004);
        src_in[5] = 1'b1; tick();
        src_in[5] = 1'b0; tick();
        vec(0, 6'd4, "R7 timer to thread0");
        wr(8'h04, 32'h0021_0021);
        req(9, 1'b1, "R9 doorbell req");
        vec(9, 6'd33, "R9 doorbell vec");
        push(3, 0, 32'h0000_0201, "R9 only target raised");
        wr(8'h04, 32'h0000_0032);
        vec(0, 6'd50, "R9 doorbell outranks source");

        tick(); tick(); tick();
        req(9, 1'b1, "R10 doorbell held");
        ipi_ack[9] = 1'b1; tick();
        ipi_ack[9] = 1'b0;
        req(9, 1'b0, "R10 acknowledged");
        ipi_ack[0] = 1'b1; tick();
        ipi_ack[0] = 1'b0;
        vec(0, 6'd4, "R10 source vec returns");
        req(0, 1'b1, "R10 source req stays");
        ipi_ack[9] = 1'b1;
        wr(8'h04, 32'h0021_000B);
        ipi_ack[9] = 1'b0;
        req(9, 1'b1, "R10 write wins over ack");
        vec(9, 6'd11, "R10 new vec");
        wr(8'h04, 32'h0073_0005);
        req(31, 1'b1, "R9 last thread req");
        vec(31, 6'd5, "R9 last thread vec");
        tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule